// File: doc/BRIEF.md
# Cluster Dormant Retention Sequencer

This block steps a processor cluster into and out of a low-power state in which the cores, the vector coprocessor, the debug logic and the level-2 cache control logic lose power. The level-2 cache RAMs are either kept powered so their contents survive (dormant mode) or switched off as well (full shutdown). On a sleep request it waits until every core reports that it is idle in wait-for-interrupt. It then asks the bus master and coherent slave ports to go inactive and waits for the level-2 memory system to report idle. Only after that does it clamp the RAM inputs and remove power.

On a wake request it restores power with every reset held. After a fixed settle time it releases the RAM clamps, then the resets. In dormant mode a reset-disable strap stays high through the whole exit and for a set number of cycles after the level-2 reset is released, so the retained cache contents are not cleared. A watchdog on the level-2 idle wait raises a flag if the idle does not come within a limit supplied on an input. All outputs come straight from flops.

Top module: `dormant_seq`

## Requirements
- R1: After reset every power enable and every active-low reset and clamp output is 1, and both inactivity requests, the reset-disable strap and the timeout flag are 0.
- R2: A sleep request has no effect on the inactivity requests until every bit of `core_wfi` is 1.
- R3: Once all cores are idle, `mst_inact` and `slv_inact` rise together one cycle later and stay high while `l2_wfi` is low, with the clamp and all power enables unchanged.
- R4: `l2_ram_iso_n` goes low only in the cycle after all cores and `l2_wfi` were seen high. One cycle later the core, coprocessor, debug and L2-control power enables drop, and all resets assert. In dormant mode (`keep_l2`=1) `pwr_l2ram_en` stays 1.
- R5: A wake request in the powered-off state turns all power enables on in the next cycle. Every reset stays 0 and the clamp stays low for exactly PWR_SETTLE cycles.
- R6: The clamp is released for exactly one cycle before the resets, and all resets deassert in the same cycle.
- R7: In dormant mode `l2_rst_dis` is 1 from power-off through the exit and stays 1 for exactly STRAP_HOLD cycles (default 32) after `l2_rst_n` rises.
- R8: Both inactivity requests fall in the same cycle as the strap and never before all resets are released.
- R9: With `keep_l2`=0 sampled at the sleep request, `pwr_l2ram_en` also drops at power-off, and `l2_rst_dis` stays 0 for the whole sequence.
- R10: While waiting for the level-2 idle, counting the first wait cycle as 0, `idle_timeout` is set if `l2_wfi` is low in any wait cycle numbered at or above `idle_limit`. An idle that arrives in cycle `idle_limit` sets no flag. The flag holds until the next sleep request is accepted, which clears it.
- R11: A wake request while the cluster is running has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_wfi | input | NUM_CORES | Per-core idle-in-WFI indication |
| l2_wfi | input | 1 | Level-2 memory system idle |
| sleep_req | input | 1 | Request to enter the low-power state |
| keep_l2 | input | 1 | 1: retain L2 RAMs (dormant), 0: full shutdown; sampled with sleep_req |
| wake_req | input | 1 | Request to leave the low-power state |
| idle_limit | input | TO_W | Wait-cycle limit for the level-2 idle |
| mst_inact | output | 1 | Bus master inactivity request |
| slv_inact | output | 1 | Coherent slave inactivity request |
| l2_ram_iso_n | output | 1 | L2 RAM input clamp, active low |
| pwr_core_en | output | NUM_CORES | Core domain power enables |
| pwr_simd_en | output | 1 | Coprocessor domain power enable |
| pwr_dbg_en | output | 1 | Debug domain power enable |
| pwr_l2ctl_en | output | 1 | L2 control domain power enable |
| pwr_l2ram_en | output | 1 | L2 RAM domain power enable |
| core_rst_n | output | NUM_CORES | Core resets, active low |
| simd_rst_n | output | 1 | Coprocessor reset, active low |
| dbg_rst_n | output | 1 | Debug reset, active low |
| l2_rst_n | output | 1 | L2 reset, active low |
| l2_rst_dis | output | 1 | L2 reset-disable strap |
| idle_timeout | output | 1 | Level-2 idle wait exceeded the limit |

## Verification
The level-2 idle can arrive in the same cycle in which the wait counter reaches `idle_limit`, so the hand-off to clamping and the timeout flag compete for that cycle. The bench finds the first wait cycle from the rise of the inactivity requests. It then raises `l2_wfi` exactly `idle_limit` cycles later, and in a second run one cycle later. It expects no flag in the first case and a set flag in the second, with the clamp falling in both. A second pairing is the strap and the inactivity requests, which must fall in the same cycle. The bench judges this by counting strap-high cycles after the L2 reset rises and checking both requests at that exact point.

// File: rtl/dormant_pkg.sv
package dormant_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_WAIT_CORES,
        ST_QUIESCE,
        ST_CLAMP,
        ST_OFF,
        ST_PWRUP,
        ST_UNCLAMP,
        ST_HOLD
    } seq_state_e;

    typedef struct packed {
        logic inact;
        logic iso_n;
        logic dom_on;
        logic ram_on;
        logic rst_n;
        logic strap;
    } seq_out_t;

    typedef struct packed {
        seq_state_e state;
        logic       keep;
        logic       err;
        seq_out_t   o;
    } seq_reg_t;

    function automatic seq_out_t seq_decode(input seq_state_e s, input logic keep);
        seq_out_t r;
        r.inact  = 1'b0;
        r.iso_n  = 1'b1;
        r.dom_on = 1'b1;
        r.ram_on = 1'b1;
        r.rst_n  = 1'b1;
        r.strap  = 1'b0;
        case (s)
            ST_QUIESCE: r.inact = 1'b1;
            ST_CLAMP: begin
                r.inact = 1'b1;
                r.iso_n = 1'b0;
            end
            ST_OFF: begin
                r.inact  = 1'b1;
                r.iso_n  = 1'b0;
                r.dom_on = 1'b0;
                r.ram_on = keep;
                r.rst_n  = 1'b0;
                r.strap  = keep;
            end
            ST_PWRUP: begin
                r.inact = 1'b1;
                r.iso_n = 1'b0;
                r.rst_n = 1'b0;
                r.strap = keep;
            end
            ST_UNCLAMP: begin
                r.inact = 1'b1;
                r.rst_n = 1'b0;
                r.strap = keep;
            end
            ST_HOLD: begin
                r.inact = 1'b1;
                r.strap = keep;
            end
            default: ;
        endcase
        return r;
    endfunction

    localparam seq_out_t SEQ_OUT_RESET = '{inact: 1'b0, iso_n: 1'b1, dom_on: 1'b1,
                                           ram_on: 1'b1, rst_n: 1'b1, strap: 1'b0};

endpackage

// File: rtl/dormant_cnt.sv
module dormant_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (cnt_q != '1)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/dormant_idle.sv
module dormant_idle #(
    parameter int NUM_CORES = 2
) (
    input  logic [NUM_CORES-1:0] core_wfi,
    input  logic                 l2_wfi,
    output logic                 all_idle,
    output logic                 ready
);

    logic [NUM_CORES:0] chain;

    assign chain[0] = 1'b1;
    for (genvar g = 0; g < NUM_CORES; g++) begin : g_and
        assign chain[g+1] = chain[g] & core_wfi[g];
    end

    assign all_idle = chain[NUM_CORES];
    assign ready    = all_idle & l2_wfi;

endmodule

// File: rtl/dormant_seq.sv
module dormant_seq
    import dormant_pkg::*;
#(
    parameter int NUM_CORES  = 2,
    parameter int PWR_SETTLE = 8,
    parameter int STRAP_HOLD = 32,
    parameter int TO_W       = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CORES-1:0] core_wfi,
    input  logic                 l2_wfi,
    input  logic                 sleep_req,
    input  logic                 keep_l2,
    input  logic                 wake_req,
    input  logic [TO_W-1:0]      idle_limit,
    output logic                 mst_inact,
    output logic                 slv_inact,
    output logic                 l2_ram_iso_n,
    output logic [NUM_CORES-1:0] pwr_core_en,
    output logic                 pwr_simd_en,
    output logic                 pwr_dbg_en,
    output logic                 pwr_l2ctl_en,
    output logic                 pwr_l2ram_en,
    output logic [NUM_CORES-1:0] core_rst_n,
    output logic                 simd_rst_n,
    output logic                 dbg_rst_n,
    output logic                 l2_rst_n,
    output logic                 l2_rst_dis,
    output logic                 idle_timeout
);

    localparam int PH_MAX = (PWR_SETTLE > STRAP_HOLD) ? PWR_SETTLE : STRAP_HOLD;
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam logic [PH_W-1:0] SETTLE_LAST = PH_W'(PWR_SETTLE - 1);
    localparam logic [PH_W-1:0] HOLD_LAST   = PH_W'(STRAP_HOLD - 1);

    seq_reg_t q, n;

    logic            all_idle, ready;
    logic [TO_W-1:0] to_cnt;
    logic [PH_W-1:0] ph_cnt;
    logic            to_clr, ph_clr;

    dormant_idle #(.NUM_CORES(NUM_CORES)) u_idle (
        .core_wfi (core_wfi),
        .l2_wfi   (l2_wfi),
        .all_idle (all_idle),
        .ready    (ready)
    );

    // Counts cycles spent waiting for the level-2 idle.
    assign to_clr = (q.state != ST_QUIESCE);
    dormant_cnt #(.W(TO_W)) u_to_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (to_clr),
        .cnt   (to_cnt)
    );

    // Shared timer for the power settle and the strap hold phases.
    assign ph_clr = !((q.state == ST_PWRUP) || (q.state == ST_HOLD));
    dormant_cnt #(.W(PH_W)) u_ph_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ph_clr),
        .cnt   (ph_cnt)
    );

    always_comb begin
        n = q;
        case (q.state)
            ST_RUN: begin
                if (sleep_req) begin
                    n.keep  = keep_l2;
                    n.err   = 1'b0;
                    n.state = ST_WAIT_CORES;
                end
            end
            ST_WAIT_CORES: begin
                if (all_idle)
                    n.state = ST_QUIESCE;
            end
            ST_QUIESCE: begin
                if (ready)
                    n.state = ST_CLAMP;
                else if (to_cnt >= idle_limit)
                    n.err = 1'b1;
            end
            ST_CLAMP: n.state = ST_OFF;
            ST_OFF: begin
                if (wake_req)
                    n.state = ST_PWRUP;
            end
            ST_PWRUP: begin
                if (ph_cnt == SETTLE_LAST)
                    n.state = ST_UNCLAMP;
            end
            ST_UNCLAMP: n.state = ST_HOLD;
            ST_HOLD: begin
                if (ph_cnt == HOLD_LAST)
                    n.state = ST_RUN;
            end
            default: n.state = ST_RUN;
        endcase
        n.o = seq_decode(n.state, n.keep);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_RUN;
            q.keep  <= 1'b1;
            q.err   <= 1'b0;
            q.o     <= SEQ_OUT_RESET;
        end else begin
            q <= n;
        end
    end

    assign mst_inact    = q.o.inact;
    assign slv_inact    = q.o.inact;
    assign l2_ram_iso_n = q.o.iso_n;
    assign pwr_core_en  = {NUM_CORES{q.o.dom_on}};
    assign pwr_simd_en  = q.o.dom_on;
    assign pwr_dbg_en   = q.o.dom_on;
    assign pwr_l2ctl_en = q.o.dom_on;
    assign pwr_l2ram_en = q.o.ram_on;
    assign core_rst_n   = {NUM_CORES{q.o.rst_n}};
    assign simd_rst_n   = q.o.rst_n;
    assign dbg_rst_n    = q.o.rst_n;
    assign l2_rst_n     = q.o.rst_n;
    assign l2_rst_dis   = q.o.strap;
    assign idle_timeout = q.err;

    // ---------------- assertions ----------------
    localparam int HC_W = $clog2(STRAP_HOLD + 1) + 1;
    logic [HC_W-1:0] rel_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rel_cnt_q <= '0;
        else if (!l2_rst_n)
            rel_cnt_q <= '0;
        else if (rel_cnt_q != '1)
            rel_cnt_q <= rel_cnt_q + 1'b1;
    end

    p_clamp_needs_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(l2_ram_iso_n) |-> $past(ready));

    p_off_is_clamped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_l2ctl_en |-> !l2_ram_iso_n);

    p_rst_at_powerup_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_simd_en) |-> (!l2_rst_n && !simd_rst_n && !dbg_rst_n));

    p_strap_min_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(l2_rst_dis) |-> (rel_cnt_q >= HC_W'(STRAP_HOLD)));

    p_inact_after_rst_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mst_inact) |-> (l2_rst_n && dbg_rst_n && simd_rst_n && (&core_rst_n)));

    p_no_strap_without_ram_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_l2ram_en |-> !l2_rst_dis);

    p_timeout_while_waiting_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_timeout) |-> $past(mst_inact && !l2_wfi));

endmodule

// File: tb/dormant_seq_bench.sv
module dormant_seq_bench;

    localparam int N      = 2;
    localparam int SETTLE = 8;
    localparam int HOLD   = 32;
    localparam int TOW    = 12;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   core_wfi = '0;
    logic           l2_wfi = 1'b0;
    logic           sleep_req = 1'b0;
    logic           keep_l2 = 1'b1;
    logic           wake_req = 1'b0;
    logic [TOW-1:0] idle_limit = TOW'(100);
    logic           mst_inact, slv_inact, l2_ram_iso_n;
    logic [N-1:0]   pwr_core_en, core_rst_n;
    logic           pwr_simd_en, pwr_dbg_en, pwr_l2ctl_en, pwr_l2ram_en;
    logic           simd_rst_n, dbg_rst_n, l2_rst_n, l2_rst_dis, idle_timeout;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    dormant_seq #(.NUM_CORES(N), .PWR_SETTLE(SETTLE), .STRAP_HOLD(HOLD), .TO_W(TOW)) u_dormant_seq (
        .clk(clk), .rst_n(rst_n), .core_wfi(core_wfi), .l2_wfi(l2_wfi),
        .sleep_req(sleep_req), .keep_l2(keep_l2), .wake_req(wake_req),
        .idle_limit(idle_limit), .mst_inact(mst_inact), .slv_inact(slv_inact),
        .l2_ram_iso_n(l2_ram_iso_n), .pwr_core_en(pwr_core_en), .pwr_simd_en(pwr_simd_en),
        .pwr_dbg_en(pwr_dbg_en), .pwr_l2ctl_en(pwr_l2ctl_en), .pwr_l2ram_en(pwr_l2ram_en),
        .core_rst_n(core_rst_n), .simd_rst_n(simd_rst_n), .dbg_rst_n(dbg_rst_n),
        .l2_rst_n(l2_rst_n), .l2_rst_dis(l2_rst_dis), .idle_timeout(idle_timeout)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pack_out();
        return {mst_inact, slv_inact, l2_ram_iso_n, &pwr_core_en, pwr_simd_en, pwr_dbg_en,
                pwr_l2ctl_en, pwr_l2ram_en, &core_rst_n, simd_rst_n, dbg_rst_n, l2_rst_n,
                l2_rst_dis, idle_timeout};
    endfunction

    // Running-state pattern: inact=0, clamp/power/resets=1, strap=0, flag=0
    localparam int RUN_PAT = 14'b00_111111_1111_00;

    task automatic wait_inact(input logic lvl);
        for (int i = 0; i < 200 && mst_inact != lvl; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(pack_out() == RUN_PAT, "R1 reset outputs", pack_out(), RUN_PAT);
    endtask

    task automatic t_wake_ignored();
        wake_req = 1'b1;
        repeat (4) @(negedge clk);
        wake_req = 1'b0;
        chk(pack_out() == RUN_PAT, "R11 wake while running", pack_out(), RUN_PAT);
    endtask

    // Enters dormant or shutdown: cores gated one by one, then L2 idle.
    task automatic t_entry(input logic keep);
        keep_l2   = keep;
        core_wfi  = 2'b01;
        l2_wfi    = 1'b0;
        sleep_req = 1'b1;
        repeat (5) @(negedge clk);
        sleep_req = 1'b0;
        chk(mst_inact == 0 && slv_inact == 0, "R2 no inact with busy core", mst_inact, 0);
        core_wfi = 2'b11;
        @(negedge clk);
        @(negedge clk);
        chk(mst_inact && slv_inact, "R3 inact after all idle", mst_inact, 1);
        repeat (3) @(negedge clk);
        chk(l2_ram_iso_n && pwr_l2ctl_en && mst_inact, "R3 waits for l2 idle", l2_ram_iso_n, 1);
        l2_wfi = 1'b1;
        @(negedge clk);
        chk(l2_ram_iso_n == 0 && pwr_simd_en == 1, "R4 clamp before power off", l2_ram_iso_n, 0);
        @(negedge clk);
        chk(pwr_core_en == 0 && !pwr_simd_en && !pwr_dbg_en && !pwr_l2ctl_en,
            "R4 domains off", pwr_l2ctl_en, 0);
        chk(core_rst_n == 0 && !l2_rst_n && !dbg_rst_n && !simd_rst_n, "R4 resets asserted", l2_rst_n, 0);
        if (keep) begin
            chk(pwr_l2ram_en == 1, "R4 ram domain kept", pwr_l2ram_en, 1);
            chk(l2_rst_dis == 1, "R7 strap high at power off", l2_rst_dis, 0);
        end else begin
            chk(pwr_l2ram_en == 0, "R9 ram domain off", pwr_l2ram_en, 0);
            chk(l2_rst_dis == 0, "R9 strap low", l2_rst_dis, 0);
        end
        core_wfi = '0;
        l2_wfi   = 1'b0;
    endtask

    task automatic t_exit(input logic keep);
        int  n_settle;
        int  n_hold;
        bit  rst_ok;
        bit  inact_ok;
        bit  strap_ok;
        repeat (3) @(negedge clk);
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        chk(pwr_simd_en && pwr_l2ctl_en && pwr_l2ram_en, "R5 power restored", pwr_l2ctl_en, 1);
        n_settle = 0;
        rst_ok   = 1'b1;
        strap_ok = 1'b1;
        for (int i = 0; i < 100 && !l2_ram_iso_n; i++) begin
            if (l2_rst_n || dbg_rst_n || simd_rst_n || (|core_rst_n) || !pwr_dbg_en) rst_ok = 1'b0;
            if (l2_rst_dis != keep) strap_ok = 1'b0;
            n_settle++;
            @(negedge clk);
        end
        chk(n_settle == SETTLE, "R5 settle cycles", n_settle, SETTLE);
        chk(rst_ok, "R5 resets held while powering", rst_ok, 1);
        chk(l2_rst_n == 0 && core_rst_n == 0, "R6 clamp released before resets", l2_rst_n, 0);
        @(negedge clk);
        chk(l2_rst_n && dbg_rst_n && simd_rst_n && (&core_rst_n), "R6 resets released together",
            l2_rst_n, 1);
        n_hold   = 0;
        inact_ok = 1'b1;
        for (int i = 0; i < 200 && mst_inact; i++) begin
            if (l2_rst_dis) n_hold++;
            if (l2_rst_dis != keep) strap_ok = 1'b0;
            if (!l2_rst_n) inact_ok = 1'b0;
            @(negedge clk);
        end
        chk(n_hold == (keep ? HOLD : 0), keep ? "R7 strap hold cycles" : "R9 strap never high",
            n_hold, keep ? HOLD : 0);
        chk(strap_ok, keep ? "R7 strap high through exit" : "R9 strap low through exit", strap_ok, 1);
        chk(inact_ok && !mst_inact && !slv_inact && !l2_rst_dis, "R8 inact falls with strap",
            mst_inact, 0);
        chk(pack_out() == RUN_PAT, "R8 back to running", pack_out(), RUN_PAT);
    endtask

    // Level-2 idle arrives n wait cycles after the first wait cycle.
    task automatic t_timeout(input int lim, input int n, input bit exp_err);
        idle_limit = TOW'(lim);
        keep_l2    = 1'b1;
        core_wfi   = '1;
        l2_wfi     = 1'b0;
        sleep_req  = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        chk(idle_timeout == 0, "R10 flag cleared on accept", idle_timeout, 0);
        wait_inact(1'b1);
        repeat (n) @(negedge clk);
        l2_wfi = 1'b1;
        @(negedge clk);
        chk(l2_ram_iso_n == 0, "R10 clamp follows idle", l2_ram_iso_n, 0);
        chk(idle_timeout == exp_err, "R10 timeout flag", idle_timeout, exp_err);
        @(negedge clk);
        chk(idle_timeout == exp_err, "R10 flag holds", idle_timeout, exp_err);
        core_wfi = '0;
        l2_wfi   = 1'b0;
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        wait_inact(1'b0);
        chk(idle_timeout == exp_err, "R10 flag holds after exit", idle_timeout, exp_err);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wake_ignored();
        t_entry(1'b1);
        t_exit(1'b1);
        t_entry(1'b0);
        t_exit(1'b0);
        t_timeout(3, 3, 1'b0);
        t_timeout(3, 4, 1'b1);
        t_timeout(3, 0, 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule